// File: doc/BRIEF.md
# Access-code and address-fence write guard

This block sits between the serial command front end of a small non-volatile memory and the array controller. It decides, for every read, write or erase the front end wants to perform, whether that access may go ahead. Two mechanisms combine in that decision. The first is a secret code of one to eight bytes: once such a code is stored, the memory stays closed to reads and changes until the code is presented. The second is an address fence: a movable pointer marks the lowest protected address, and every change at or above it is refused. A lock command and a one-instruction fence bypass complete the set.

The front end delivers a command byte on `cmd_valid`, then the operand bytes of that command one per `byte_valid` strobe. Accesses are presented on `req_valid` with a kind and an address, and `grant` answers in the same cycle. The stored code, its length and the pointer survive the warm reset `rst_n`; only the power-on reset `por_n` clears them. A wrong code sets a sticky error flag that stays up until the next warm reset.

Top module: `pwguard`

## Requirements
- R1: After `por_n` no code is stored, the pointer holds 16'hFFFF, and `err`, `locked` and `ptr_rd_valid` are 0; a warm reset (`rst_n` low for one cycle) keeps code, length and pointer, clears `err`, and leaves `locked` at 1 whenever a nonzero code length is stored, with every access then denied.
- R2: With no code stored, reads (`req_kind` 0) are granted at any address, and writes (kind 1) and erases (kind 2) are granted below the pointer.
- R3: The code-change command is 1101 in the upper nibble with the new length L in the lower nibble; with no code stored, its operands are the L new code bytes followed by the same L bytes again. When both entries match, the code of length L is stored and the device stays open (`locked` 0).
- R4: A code change whose second entry differs from the first stores nothing, the old code stays valid, and `err` goes to 1.
- R5: When a code is stored, a code change first takes the stored-length old code bytes; a wrong old code sets `err` and leaves the stored code unchanged.
- R6: A code change with L = 0 (after a correct old code) removes the code, so the device is unprotected and not locked, also after a warm reset.
- R7: A code change with L greater than 8 ignores all of its operand bytes, sets no error and changes no state.
- R8: The unlock command 8'hC5 followed by the stored code (bytes in the order they were entered) clears `locked`, opening reads and writes; a wrong code keeps `locked` at 1 and sets `err`. With no code stored, 8'hC5 takes no operands.
- R9: The lock command 8'h88 denies every write and erase whatever the pointer or a pending bypass; reads are unaffected, and only a successful unlock lifts it.
- R10: The pointer-load command 8'hC4 takes two address bytes, high byte first, when `org_x16` is 0, and one byte (upper byte zero) when `org_x16` is 1; it takes effect only while reads are permitted and is otherwise ignored.
- R11: The pointer-read command 8'hCA raises `ptr_rd_valid` for exactly one cycle, starting one cycle after the command, with the pointer on `ptr_rd_data`.
- R12: A write or erase at an address at or above the pointer is denied (in x16 organization only the low address byte is compared with the low pointer byte); `req_kind` 3 is always denied.
- R13: The bypass command 8'h83 lifts the fence for the next instruction only, whether that is an access or another command; the fence applies again afterwards.
- R14: While `err` is 1, every command and operand byte is ignored until a warm reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; clears stored code and pointer |
| rst_n | input | 1 | Warm reset, synchronous, active low; keeps code, length and pointer |
| org_x16 | input | 1 | 1: 16-bit word organization (8-bit addresses); 0: byte organization (16-bit addresses) |
| cmd_valid | input | 1 | A command byte is present |
| cmd_code | input | 8 | Command byte |
| byte_valid | input | 1 | An operand byte of the current command is present |
| byte_data | input | 8 | Operand byte |
| req_valid | input | 1 | An access is presented for decision |
| req_kind | input | 2 | 0 read, 1 write, 2 erase, 3 reserved |
| req_addr | input | 16 | Address of the access |
| grant | output | 1 | Access allowed (combinational, same cycle as `req_valid`) |
| err | output | 1 | Sticky wrong-code flag |
| locked | output | 1 | A code is stored and has not been presented |
| ptr_rd_valid | output | 1 | Pointer readback strobe |
| ptr_rd_data | output | 16 | Pointer value |

## Verification
The bench goes after the ordering corners: a bypass consumed by an intervening command rather than an access, a lock that must beat a pending bypass, and a pointer load sent while locked, which a careless design would apply and so move the fence. It checks that a mismatched re-entry or wrong old code leaves the previous code usable after a warm reset, which a design that committed early would fail by refusing the old code. It drives an over-long length field whose operand bytes happen to look like a code, and checks that warm reset keeps the stored code and so keeps the device locked, which a design resetting the code would expose by reporting unlocked.

// File: rtl/pwg_pkg.sv
package pwg_pkg;

    localparam int ADDR_W = 16;

    // command bytes
    localparam logic [7:0] OP_LOCK = 8'h88;
    localparam logic [7:0] OP_OPEN = 8'hC5;
    localparam logic [7:0] OP_PLD  = 8'hC4;
    localparam logic [7:0] OP_PRD  = 8'hCA;
    localparam logic [7:0] OP_BYP  = 8'h83;
    localparam logic [3:0] OPN_CHG = 4'hD;

    // access kinds
    localparam logic [1:0] KIND_RD = 2'd0;
    localparam logic [1:0] KIND_WR = 2'd1;
    localparam logic [1:0] KIND_ER = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_OLD,
        ST_NEW1,
        ST_NEW2,
        ST_PTR,
        ST_SKIP
    } phase_t;

endpackage

// File: rtl/pwg_fence.sv
module pwg_fence
    import pwg_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              org_x16,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              read_ok,
    input  logic              wr_block,
    input  logic              bypass,
    input  logic [ADDR_W-1:0] ptr,
    output logic              grant
);

    logic fenced;
    logic is_chg;

    always_comb begin
        if (org_x16) fenced = (req_addr[7:0] >= ptr[7:0]);
        else         fenced = (req_addr >= ptr);
        is_chg = (req_kind == KIND_WR) || (req_kind == KIND_ER);
        grant  = 1'b0;
        if (req_valid && read_ok) begin
            if (req_kind == KIND_RD)  grant = 1'b1;
            else if (is_chg)          grant = !wr_block && (!fenced || bypass);
        end
    end

    assert_gate_open_R8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        grant |-> read_ok);

    assert_lock_blocks_R9: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (grant && req_kind != KIND_RD) |-> !wr_block);

    assert_reserved_R12: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (req_valid && req_kind == 2'd3) |-> !grant);

    assert_below_fence_R12: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (grant && req_kind != KIND_RD && !bypass && !org_x16) |-> (req_addr < ptr));

endmodule

// File: rtl/pwg_ctrl.sv
module pwg_ctrl
    import pwg_pkg::*;
#(
    parameter int CODE_BYTES = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              org_x16,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_code,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              req_valid,
    output logic              read_ok,
    output logic              wr_block,
    output logic              bypass,
    output logic [ADDR_W-1:0] ptr,
    output logic              err,
    output logic              locked,
    output logic              prd_valid
);

    localparam int CW = CODE_BYTES * 8;
    localparam int IW = (CODE_BYTES > 1) ? $clog2(CODE_BYTES) : 1;
    localparam logic [3:0] LEN_MAX = 4'(CODE_BYTES);

    typedef struct packed {
        phase_t            state;
        logic [3:0]        cnt;
        logic [3:0]        need;
        logic [3:0]        newlen;
        logic              bad;
        logic [CW-1:0]     tmp;
        logic [CW-1:0]     code;
        logic [3:0]        len;
        logic              open;
        logic              wblk;
        logic              byp;
        logic              err;
        logic [ADDR_W-1:0] ptr;
        logic              prd;
    } regs_t;

    regs_t q, d;

    logic [IW-1:0] idx;
    logic [7:0]    cur_code;
    logic [7:0]    cur_tmp;
    logic          last;
    logic          rd_ok;

    always_comb begin
        idx      = q.cnt[IW-1:0];
        cur_code = q.code[{idx, 3'b000} +: 8];
        cur_tmp  = q.tmp[{idx, 3'b000} +: 8];
        last     = (q.cnt == q.need - 4'd1);
        rd_ok    = (q.len == 4'd0) || q.open;

        d     = q;
        d.prd = 1'b0;
        if (req_valid) d.byp = 1'b0;

        if (cmd_valid && !q.err) begin
            d.byp   = 1'b0;
            d.state = ST_IDLE;
            d.cnt   = 4'd0;
            d.bad   = 1'b0;
            d.tmp   = '0;
            if (cmd_code[7:4] == OPN_CHG) begin
                if (cmd_code[3:0] > LEN_MAX) begin
                    d.state = ST_SKIP;
                end else begin
                    d.newlen = cmd_code[3:0];
                    if (q.len != 4'd0) begin
                        d.state = ST_OLD;
                        d.need  = q.len;
                    end else if (cmd_code[3:0] != 4'd0) begin
                        d.state = ST_NEW1;
                        d.need  = cmd_code[3:0];
                    end else begin
                        d.len  = 4'd0;
                        d.code = '0;
                    end
                end
            end else begin
                case (cmd_code)
                    OP_LOCK: d.wblk = 1'b1;
                    OP_OPEN: begin
                        if (q.len == 4'd0) begin
                            d.open = 1'b1;
                            d.wblk = 1'b0;
                        end else begin
                            d.state = ST_OPEN;
                            d.need  = q.len;
                        end
                    end
                    OP_PLD: begin
                        d.state = ST_PTR;
                        d.need  = org_x16 ? 4'd1 : 4'd2;
                    end
                    OP_PRD: d.prd = 1'b1;
                    OP_BYP: d.byp = 1'b1;
                    default: ;
                endcase
            end
        end else if (byte_valid && !q.err) begin
            d.cnt = q.cnt + 4'd1;
            case (q.state)
                ST_OPEN: begin
                    d.bad = q.bad || (byte_data != cur_code);
                    if (last) begin
                        d.state = ST_IDLE;
                        d.cnt   = 4'd0;
                        if (d.bad) begin
                            d.err = 1'b1;
                        end else begin
                            d.open = 1'b1;
                            d.wblk = 1'b0;
                        end
                    end
                end
                ST_OLD: begin
                    d.bad = q.bad || (byte_data != cur_code);
                    if (last) begin
                        d.cnt   = 4'd0;
                        d.bad   = 1'b0;
                        d.state = ST_IDLE;
                        if (q.bad || (byte_data != cur_code)) begin
                            d.err = 1'b1;
                        end else if (q.newlen == 4'd0) begin
                            d.len  = 4'd0;
                            d.code = '0;
                        end else begin
                            d.state = ST_NEW1;
                            d.need  = q.newlen;
                        end
                    end
                end
                ST_NEW1: begin
                    d.tmp[{idx, 3'b000} +: 8] = byte_data;
                    if (last) begin
                        d.state = ST_NEW2;
                        d.cnt   = 4'd0;
                    end
                end
                ST_NEW2: begin
                    d.bad = q.bad || (byte_data != cur_tmp);
                    if (last) begin
                        d.state = ST_IDLE;
                        d.cnt   = 4'd0;
                        if (d.bad) begin
                            d.err = 1'b1;
                        end else begin
                            d.code = q.tmp;
                            d.len  = q.newlen;
                            d.open = 1'b1;
                        end
                    end
                end
                ST_PTR: begin
                    d.tmp[15:0] = {q.tmp[7:0], byte_data};
                    if (last) begin
                        d.state = ST_IDLE;
                        d.cnt   = 4'd0;
                        if (rd_ok) d.ptr = org_x16 ? {8'h00, byte_data} : {q.tmp[7:0], byte_data};
                    end
                end
                default: d.cnt = q.cnt;
            endcase
        end

        if (!rst_n) begin
            d      = '0;
            d.code = q.code;
            d.len  = q.len;
            d.ptr  = q.ptr;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q     <= '0;
            q.ptr <= '1;
        end else begin
            q <= d;
        end
    end

    assign read_ok   = rd_ok;
    assign wr_block  = q.wblk;
    assign bypass    = q.byp;
    assign ptr       = q.ptr;
    assign err       = q.err;
    assign locked    = (q.len != 4'd0) && !q.open;
    assign prd_valid = q.prd;

    assert_err_sticky_R14: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        q.err |=> q.err);

    assert_err_from_byte_R8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $rose(q.err) |-> $past(byte_valid));

    assert_ptr_source_R10: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        !$stable(q.ptr) |-> $past(byte_valid && q.state == ST_PTR));

    assert_bypass_once_R13: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (q.byp && req_valid && !cmd_valid) |=> !q.byp);

    assert_prd_cause_R11: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        q.prd |-> $past(cmd_valid && cmd_code == OP_PRD));

endmodule

// File: rtl/pwguard.sv
module pwguard
    import pwg_pkg::*;
#(
    parameter int CODE_BYTES = 8
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        rst_n,
    input  logic        org_x16,
    input  logic        cmd_valid,
    input  logic [7:0]  cmd_code,
    input  logic        byte_valid,
    input  logic [7:0]  byte_data,
    input  logic        req_valid,
    input  logic [1:0]  req_kind,
    input  logic [15:0] req_addr,
    output logic        grant,
    output logic        err,
    output logic        locked,
    output logic        ptr_rd_valid,
    output logic [15:0] ptr_rd_data
);

    logic              read_ok;
    logic              wr_block;
    logic              bypass;
    logic [ADDR_W-1:0] ptr;

    pwg_ctrl #(.CODE_BYTES(CODE_BYTES)) u_ctrl (
        .clk        (clk),
        .por_n      (por_n),
        .rst_n      (rst_n),
        .org_x16    (org_x16),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .req_valid  (req_valid),
        .read_ok    (read_ok),
        .wr_block   (wr_block),
        .bypass     (bypass),
        .ptr        (ptr),
        .err        (err),
        .locked     (locked),
        .prd_valid  (ptr_rd_valid)
    );

    pwg_fence u_fence (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .org_x16   (org_x16),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .read_ok   (read_ok),
        .wr_block  (wr_block),
        .bypass    (bypass),
        .ptr       (ptr),
        .grant     (grant)
    );

    assign ptr_rd_data = ptr;

endmodule

// File: tb/sim_pwguard.sv
`timescale 1ns/1ps
module sim_pwguard;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b0;
    logic        org_x16 = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = 8'h00;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] req_addr = 16'h0000;
    logic        grant, err, locked, ptr_rd_valid;
    logic [15:0] ptr_rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pwguard u0 (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .org_x16(org_x16),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .grant(grant), .err(err), .locked(locked),
        .ptr_rd_valid(ptr_rd_valid), .ptr_rd_data(ptr_rd_data)
    );

    // [27:24] req, [23:22] op (0 cmd, 1 byte, 2 access, 3 warm reset),
    // [21:20] kind, [19:4] data/addr, [2] grant, [1] err, [0] locked
    function automatic logic [27:0] mk(input logic [3:0] r, input logic [1:0] op,
                                       input logic [1:0] k, input logic [15:0] w,
                                       input logic g, input logic e, input logic l);
        return {r, op, k, w, 1'b0, g, e, l};
    endfunction

    localparam int NV = 76;
    localparam logic [27:0] VEC [NV] = '{
        mk(4'd2, 2'd2, 2'd0, 16'h0010, 1, 0, 0),   // R2 read open
        mk(4'd2, 2'd2, 2'd1, 16'h0010, 1, 0, 0),   // R2 write below fence
        mk(4'd12,2'd2, 2'd1, 16'hFFFF, 0, 0, 0),   // R12 at fence
        mk(4'd10,2'd0, 2'd0, 16'h00C4, 0, 0, 0),   // R10 load pointer
        mk(4'd10,2'd1, 2'd0, 16'h0001, 0, 0, 0),
        mk(4'd10,2'd1, 2'd0, 16'h0000, 0, 0, 0),   // pointer = 0x0100
        mk(4'd12,2'd2, 2'd1, 16'h00FF, 1, 0, 0),   // R12 just below
        mk(4'd12,2'd2, 2'd2, 16'h0100, 0, 0, 0),   // R12 erase at fence
        mk(4'd12,2'd2, 2'd3, 16'h0000, 0, 0, 0),   // R12 reserved kind
        mk(4'd13,2'd0, 2'd0, 16'h0083, 0, 0, 0),   // R13 bypass
        mk(4'd13,2'd2, 2'd1, 16'h0200, 1, 0, 0),
        mk(4'd13,2'd2, 2'd1, 16'h0200, 0, 0, 0),   // R13 rearmed
        mk(4'd13,2'd0, 2'd0, 16'h0083, 0, 0, 0),
        mk(4'd13,2'd0, 2'd0, 16'h00CA, 0, 0, 0),   // command consumes bypass
        mk(4'd13,2'd2, 2'd1, 16'h0200, 0, 0, 0),
        mk(4'd9, 2'd0, 2'd0, 16'h0088, 0, 0, 0),   // R9 lock
        mk(4'd9, 2'd2, 2'd1, 16'h0000, 0, 0, 0),
        mk(4'd9, 2'd2, 2'd0, 16'h0000, 1, 0, 0),
        mk(4'd9, 2'd0, 2'd0, 16'h0083, 0, 0, 0),
        mk(4'd9, 2'd2, 2'd1, 16'h0000, 0, 0, 0),   // R9 lock beats bypass
        mk(4'd8, 2'd0, 2'd0, 16'h00C5, 0, 0, 0),   // R8 unlock, no code
        mk(4'd9, 2'd2, 2'd1, 16'h0000, 1, 0, 0),
        mk(4'd7, 2'd0, 2'd0, 16'h00DA, 0, 0, 0),   // R7 length 10
        mk(4'd7, 2'd1, 2'd0, 16'h0055, 0, 0, 0),
        mk(4'd7, 2'd1, 2'd0, 16'h0055, 0, 0, 0),
        mk(4'd3, 2'd0, 2'd0, 16'h00D2, 0, 0, 0),   // R3 set 2-byte code
        mk(4'd3, 2'd1, 2'd0, 16'h00A1, 0, 0, 0),
        mk(4'd3, 2'd1, 2'd0, 16'h00B2, 0, 0, 0),
        mk(4'd3, 2'd1, 2'd0, 16'h00A1, 0, 0, 0),
        mk(4'd3, 2'd1, 2'd0, 16'h00B2, 0, 0, 0),
        mk(4'd1, 2'd3, 2'd0, 16'h0000, 0, 0, 1),   // R1 warm reset keeps code
        mk(4'd1, 2'd2, 2'd0, 16'h0000, 0, 0, 1),
        mk(4'd1, 2'd2, 2'd1, 16'h0000, 0, 0, 1),
        mk(4'd10,2'd0, 2'd0, 16'h00C4, 0, 0, 1),   // R10 load while locked
        mk(4'd10,2'd1, 2'd0, 16'h0000, 0, 0, 1),
        mk(4'd10,2'd1, 2'd0, 16'h0010, 0, 0, 1),
        mk(4'd8, 2'd0, 2'd0, 16'h00C5, 0, 0, 1),   // R8 unlock
        mk(4'd8, 2'd1, 2'd0, 16'h00A1, 0, 0, 1),
        mk(4'd8, 2'd1, 2'd0, 16'h00B2, 0, 0, 0),
        mk(4'd8, 2'd2, 2'd0, 16'h0000, 1, 0, 0),
        mk(4'd10,2'd2, 2'd1, 16'h00FF, 1, 0, 0),   // R10 pointer unchanged
        mk(4'd4, 2'd0, 2'd0, 16'h00D3, 0, 0, 0),   // R4 change, bad re-entry
        mk(4'd4, 2'd1, 2'd0, 16'h00A1, 0, 0, 0),
        mk(4'd4, 2'd1, 2'd0, 16'h00B2, 0, 0, 0),
        mk(4'd4, 2'd1, 2'd0, 16'h0011, 0, 0, 0),
        mk(4'd4, 2'd1, 2'd0, 16'h0022, 0, 0, 0),
        mk(4'd4, 2'd1, 2'd0, 16'h0033, 0, 0, 0),
        mk(4'd4, 2'd1, 2'd0, 16'h0011, 0, 0, 0),
        mk(4'd4, 2'd1, 2'd0, 16'h0022, 0, 0, 0),
        mk(4'd4, 2'd1, 2'd0, 16'h0034, 0, 1, 0),
        mk(4'd14,2'd0, 2'd0, 16'h0088, 0, 1, 0),   // R14 lock ignored
        mk(4'd14,2'd2, 2'd1, 16'h0000, 1, 1, 0),
        mk(4'd14,2'd3, 2'd0, 16'h0000, 0, 0, 1),
        mk(4'd4, 2'd0, 2'd0, 16'h00C5, 0, 0, 1),   // R4 old code still valid
        mk(4'd4, 2'd1, 2'd0, 16'h00A1, 0, 0, 1),
        mk(4'd4, 2'd1, 2'd0, 16'h00B2, 0, 0, 0),
        mk(4'd5, 2'd0, 2'd0, 16'h00D1, 0, 0, 0),   // R5 wrong old code
        mk(4'd5, 2'd1, 2'd0, 16'h00A1, 0, 0, 0),
        mk(4'd5, 2'd1, 2'd0, 16'h0000, 0, 1, 0),
        mk(4'd5, 2'd3, 2'd0, 16'h0000, 0, 0, 1),
        mk(4'd5, 2'd0, 2'd0, 16'h00C5, 0, 0, 1),
        mk(4'd5, 2'd1, 2'd0, 16'h00A1, 0, 0, 1),
        mk(4'd5, 2'd1, 2'd0, 16'h00B2, 0, 0, 0),
        mk(4'd8, 2'd3, 2'd0, 16'h0000, 0, 0, 1),   // R8 wrong unlock
        mk(4'd8, 2'd0, 2'd0, 16'h00C5, 0, 0, 1),
        mk(4'd8, 2'd1, 2'd0, 16'h00A1, 0, 0, 1),
        mk(4'd8, 2'd1, 2'd0, 16'h0000, 0, 1, 1),
        mk(4'd8, 2'd3, 2'd0, 16'h0000, 0, 0, 1),
        mk(4'd6, 2'd0, 2'd0, 16'h00C5, 0, 0, 1),   // R6 remove code
        mk(4'd6, 2'd1, 2'd0, 16'h00A1, 0, 0, 1),
        mk(4'd6, 2'd1, 2'd0, 16'h00B2, 0, 0, 0),
        mk(4'd6, 2'd0, 2'd0, 16'h00D0, 0, 0, 0),
        mk(4'd6, 2'd1, 2'd0, 16'h00A1, 0, 0, 0),
        mk(4'd6, 2'd1, 2'd0, 16'h00B2, 0, 0, 0),
        mk(4'd6, 2'd3, 2'd0, 16'h0000, 0, 0, 0),
        mk(4'd6, 2'd2, 2'd1, 16'h0000, 1, 0, 0)
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic run_vec(input int i, input logic [27:0] v);
        string tag;
        tag = $sformatf("R%0d step %0d", v[27:24], i);
        case (v[23:22])
            2'd0: begin cmd_valid = 1'b1; cmd_code = v[11:4]; end
            2'd1: begin byte_valid = 1'b1; byte_data = v[11:4]; end
            2'd2: begin req_valid = 1'b1; req_kind = v[21:20]; req_addr = v[19:4]; end
            default: rst_n = 1'b0;
        endcase
        #1;
        if (v[23:22] == 2'd2) chk({tag, " grant"}, 16'(grant), 16'(v[2]));
        @(negedge clk);
        cmd_valid = 1'b0; byte_valid = 1'b0; req_valid = 1'b0; rst_n = 1'b1;
        chk({tag, " err"}, 16'(err), 16'(v[1]));
        chk({tag, " locked"}, 16'(locked), 16'(v[0]));
    endtask

    task automatic req_chk(input string tag, input logic [1:0] k, input logic [15:0] a, input logic g);
        req_valid = 1'b1; req_kind = k; req_addr = a;
        #1;
        chk(tag, 16'(grant), 16'(g));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_cmd(input logic [7:0] c);
        cmd_valid = 1'b1; cmd_code = c;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        byte_valid = 1'b1; byte_data = b;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1 power-on state
        chk("R1 err after por", 16'(err), 16'd0);
        chk("R1 locked after por", 16'(locked), 16'd0);
        chk("R1 ptr_rd_valid idle", 16'(ptr_rd_valid), 16'd0);
        send_cmd(8'hCA);
        chk("R11 readback strobe", 16'(ptr_rd_valid), 16'd1);
        chk("R1 pointer after por", ptr_rd_data, 16'hFFFF);
        @(negedge clk);
        chk("R11 strobe one cycle", 16'(ptr_rd_valid), 16'd0);

        for (int i = 0; i < NV; i++) run_vec(i, VEC[i]);

        // R10 / R12 x16 organization: one address byte, low byte compare
        org_x16 = 1'b1;
        @(negedge clk);
        send_cmd(8'hC4);
        send_byte(8'h20);
        send_cmd(8'hCA);
        chk("R11 x16 strobe", 16'(ptr_rd_valid), 16'd1);
        chk("R10 x16 pointer", ptr_rd_data, 16'h0020);
        req_chk("R12 x16 below", 2'd1, 16'h001F, 1'b1);
        req_chk("R12 x16 at fence", 2'd1, 16'h0020, 1'b0);
        req_chk("R12 x16 low byte only", 2'd2, 16'h0110, 1'b1);
        req_chk("R2 x16 read above", 2'd0, 16'h00F0, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule